// File: doc/BRIEF.md
# Sleep Mode and Wake Controller

This block is the power manager of a small microcontroller. Software writes a control register that holds a sleep-enable bit, a two-bit sleep-mode code and a two-bit stabilisation-delay select. When the core raises its sleep request and sleep is enabled, the block latches the mode. It then drops the clock enables that the mode calls for: the CPU clock, the I/O clock that feeds the generated peripheral clocks, and the clock of a timer that can run from an asynchronous source.

While asleep, the block watches its wake inputs. Which inputs count depends on the latched mode. A level-type wake line counts only after it has been held for a minimum number of cycles. A valid wake loads a down-counter from the delay select, and the counter steps on a slow tick. The clocks come back only when the counter is empty. A one-cycle resume strobe marks the cycle in which they return.

A second register holds one gating bit per peripheral. A set bit turns that peripheral's clock off while the core runs or idles. The deeper modes force every peripheral clock off regardless of this register.

Top module: `pwr_sleep_ctrl`

## Requirements
- R1: After reset, the CPU, I/O and timer clock enables and all peripheral clock enables are 1. `asleep`, `resume` and `tmr_invalid` are 0, and both registers read 0.
- R2: A sleep request while the sleep-enable bit (control bit 0) is 0 is ignored, and every clock enable stays 1.
- R3: Mode codes 2'b00 and 2'b01 (control bits 2:1) give idle. The CPU clock stops, the I/O and timer clocks run, and each peripheral clock enable equals the inverse of its gating bit.
- R4: Mode code 2'b10 gives power-down. The CPU, I/O, timer and all peripheral clock enables are 0 until the core resumes.
- R5: Mode code 2'b11 gives power-save. It matches power-down, except that the timer clock enable follows `tmr_async_sel`.
- R6: In power-down, each of external reset, watchdog, brown-out, serial start condition, pin change and a qualified level line wakes the block. Timer events do not wake it.
- R7: A timer overflow or compare event wakes the block only if its own enable and `irq_global_en` are both 1. In power-save it also needs `tmr_async_sel` at 1, and in power-down it never wakes the block. In idle, both timer events and the power-down sources wake it.
- R8: A level wake line counts only if it is sampled high on LVL_HOLD (default 4) consecutive clock edges. A shorter pulse leaves the block asleep.
- R9: A wake loads the counter with 6, 16, 64 or 256 for delay select 0 to 3 (control bits 4:3). The counter decrements only on clock edges where `slow_tick` is 1. One edge after it reaches zero, the clocks return and `resume` is 1 for exactly one cycle.
- R10: Gating register (address 1) bit i at 1 sets `periph_clk_en[i]` to 0 while running. Clearing the bit restores the enable to 1.
- R11: A wake from power-save with `tmr_async_sel` at 0 sets `tmr_invalid`. The next accepted sleep request clears it.
- R12: Writes to address 0 (control, bits 4:0) and address 1 (gating, bits NPERIPH-1:0) read back on `cfg_rdata` at the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | AW | Register address (0 control, 1 gating) |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data for `cfg_addr` |
| sleep_req | input | 1 | Core sleep request |
| slow_tick | input | 1 | Stabilisation time base enable |
| wk_ext_rst | input | 1 | External reset wake |
| wk_wdt | input | 1 | Watchdog reset or interrupt wake |
| wk_bod | input | 1 | Brown-out wake |
| wk_serial_start | input | 1 | Serial start-condition wake |
| wk_pin_chg | input | 1 | Pin-change wake |
| wk_level | input | NLVL | Level-triggered external wake lines |
| tmr_ovf_evt | input | 1 | Async timer overflow event |
| tmr_cmp_evt | input | 1 | Async timer compare event |
| tmr_ovf_ie | input | 1 | Overflow interrupt enable |
| tmr_cmp_ie | input | 1 | Compare interrupt enable |
| irq_global_en | input | 1 | Global interrupt enable |
| tmr_async_sel | input | 1 | Timer runs from asynchronous clock |
| cpu_clk_en | output | 1 | CPU clock enable |
| io_clk_en | output | 1 | I/O clock enable |
| tmr_clk_en | output | 1 | Async timer clock enable |
| periph_clk_en | output | NPERIPH | Per-peripheral clock enables |
| resume | output | 1 | One-cycle strobe when clocks return |
| asleep | output | 1 | Core clock is stopped (sleeping or stabilising) |
| tmr_invalid | output | 1 | Timer contents undefined after power-save wake |

## Verification
The hardest case to reach is a wake that has to be rejected while all of its other conditions hold. Examples are a timer event with every enable set during power-down, or in power-save with the asynchronous select at 0, and a level line dropped one edge short of the hold time. The stimulus enters each deep mode and raises the near-miss source first, confirming at the ports that the block is still asleep. It then uses a genuine source and counts edges to the exact resume cycle. Holding `slow_tick` low after a wake shows that the counter is frozen rather than merely slow.

// File: rtl/pwr_pkg.sv
package pwr_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE  = 2'b00,
        MODE_RSVD  = 2'b01,
        MODE_PDOWN = 2'b10,
        MODE_PSAVE = 2'b11
    } sleep_mode_e;

    typedef enum logic [1:0] {
        ST_RUN   = 2'b00,
        ST_SLEEP = 2'b01,
        ST_STAB  = 2'b10
    } pwr_state_e;

    // Control register image, bit 0 is sleep enable
    typedef struct packed {
        logic [1:0]  stab_sel;
        sleep_mode_e mode;
        logic        sleep_en;
    } ctrl_t;

    typedef struct packed {
        logic ext_rst;
        logic wdt;
        logic bod;
        logic serial_start;
        logic pin_chg;
    } async_wake_t;

    typedef struct packed {
        logic ovf_evt;
        logic cmp_evt;
        logic ovf_ie;
        logic cmp_ie;
        logic gie;
        logic async_sel;
    } tmr_wake_t;

    localparam int STAB_W = 9;
    localparam int REG_DW = 8;

    function automatic logic [STAB_W-1:0] stab_ticks(input logic [1:0] sel);
        logic [STAB_W-1:0] n;
        case (sel)
            2'd0:    n = STAB_W'(6);
            2'd1:    n = STAB_W'(16);
            2'd2:    n = STAB_W'(64);
            default: n = STAB_W'(256);
        endcase
        return n;
    endfunction

    function automatic logic mode_is_deep(input sleep_mode_e m);
        return m[1];
    endfunction

endpackage

// File: rtl/pwr_regs.sv
module pwr_regs
    import pwr_pkg::*;
#(
    parameter int NPERIPH = 4,
    parameter int AW      = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  logic [AW-1:0]       addr,
    input  logic [REG_DW-1:0]   wdata,
    output ctrl_t               ctrl,
    output logic [NPERIPH-1:0]  gate,
    output logic [REG_DW-1:0]   rdata
);
    localparam int CW = $bits(ctrl_t);
    localparam logic [AW-1:0] A_CTRL = AW'(0);
    localparam logic [AW-1:0] A_GATE = AW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            gate <= '0;
        end else if (we) begin
            if (addr == A_CTRL) ctrl <= ctrl_t'(wdata[CW-1:0]);
            if (addr == A_GATE) gate <= wdata[NPERIPH-1:0];
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == A_CTRL) rdata[CW-1:0] = ctrl;
        if (addr == A_GATE) rdata[NPERIPH-1:0] = gate;
    end

endmodule

// File: rtl/pwr_wake_qual.sv
module pwr_wake_qual
    import pwr_pkg::*;
#(
    parameter int NLVL     = 2,
    parameter int LVL_HOLD = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             armed,
    input  sleep_mode_e      mode,
    input  async_wake_t      src,
    input  logic [NLVL-1:0]  lvl,
    input  tmr_wake_t        tmr,
    output logic             wake
);
    localparam int HW = (LVL_HOLD > 2) ? $clog2(LVL_HOLD) : 1;
    localparam logic [HW-1:0] HOLD_MAX = HW'(LVL_HOLD - 1);

    logic [NLVL-1:0] lvl_ok;
    logic            tmr_hit;
    logic            tmr_ok;

    for (genvar i = 0; i < NLVL; i++) begin : g_lvl
        logic [HW-1:0] hold_q;

        always_ff @(posedge clk) begin
            if (rst || !lvl[i])          hold_q <= '0;
            else if (hold_q != HOLD_MAX) hold_q <= hold_q + 1'b1;
        end

        assign lvl_ok[i] = lvl[i] && (hold_q == HOLD_MAX);

        // R8
        lvl_held_chk: assert property (@(posedge clk) disable iff (rst)
            lvl_ok[i] |-> $past(lvl[i]));
    end

    assign tmr_hit = tmr.gie && ((tmr.ovf_evt && tmr.ovf_ie) || (tmr.cmp_evt && tmr.cmp_ie));

    always_comb begin
        case (mode)
            MODE_PDOWN: tmr_ok = 1'b0;
            MODE_PSAVE: tmr_ok = tmr_hit && tmr.async_sel;
            default:    tmr_ok = tmr_hit;
        endcase
    end

    assign wake = armed && ((|src) || (|lvl_ok) || tmr_ok);

endmodule

// File: rtl/pwr_stab_cnt.sv
module pwr_stab_cnt
    import pwr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [STAB_W-1:0] load_val,
    input  logic              tick,
    output logic              busy,
    output logic              done
);
    logic [STAB_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            busy <= 1'b0;
        end else if (load) begin
            cnt  <= load_val;
            busy <= 1'b1;
        end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else if (tick) cnt <= cnt - 1'b1;
        end
    end

    assign done = busy && (cnt == '0);

    // R9
    stab_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !tick && !load) |=> (cnt == $past(cnt)));

endmodule

// File: rtl/pwr_sleep_ctrl.sv
module pwr_sleep_ctrl
    import pwr_pkg::*;
#(
    parameter int NPERIPH  = 4,
    parameter int NLVL     = 2,
    parameter int LVL_HOLD = 4,
    parameter int AW       = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [AW-1:0]      cfg_addr,
    input  logic [7:0]         cfg_wdata,
    output logic [7:0]         cfg_rdata,
    input  logic               sleep_req,
    input  logic               slow_tick,
    input  logic               wk_ext_rst,
    input  logic               wk_wdt,
    input  logic               wk_bod,
    input  logic               wk_serial_start,
    input  logic               wk_pin_chg,
    input  logic [NLVL-1:0]    wk_level,
    input  logic               tmr_ovf_evt,
    input  logic               tmr_cmp_evt,
    input  logic               tmr_ovf_ie,
    input  logic               tmr_cmp_ie,
    input  logic               irq_global_en,
    input  logic               tmr_async_sel,
    output logic               cpu_clk_en,
    output logic               io_clk_en,
    output logic               tmr_clk_en,
    output logic [NPERIPH-1:0] periph_clk_en,
    output logic               resume,
    output logic               asleep,
    output logic               tmr_invalid
);
    ctrl_t               ctrl;
    logic [NPERIPH-1:0]  gate;
    pwr_state_e          state;
    sleep_mode_e         mode_q;
    logic                wake;
    logic                stab_busy;
    logic                stab_done;
    logic                stab_load;
    async_wake_t         src;
    tmr_wake_t           tmr;

    assign src = '{ext_rst: wk_ext_rst, wdt: wk_wdt, bod: wk_bod,
                   serial_start: wk_serial_start, pin_chg: wk_pin_chg};
    assign tmr = '{ovf_evt: tmr_ovf_evt, cmp_evt: tmr_cmp_evt, ovf_ie: tmr_ovf_ie,
                   cmp_ie: tmr_cmp_ie, gie: irq_global_en, async_sel: tmr_async_sel};

    pwr_regs #(.NPERIPH(NPERIPH), .AW(AW)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .ctrl  (ctrl),
        .gate  (gate),
        .rdata (cfg_rdata)
    );

    pwr_wake_qual #(.NLVL(NLVL), .LVL_HOLD(LVL_HOLD)) u_wake (
        .clk   (clk),
        .rst   (rst),
        .armed (state == ST_SLEEP),
        .mode  (mode_q),
        .src   (src),
        .lvl   (wk_level),
        .tmr   (tmr),
        .wake  (wake)
    );

    assign stab_load = (state == ST_SLEEP) && wake;

    pwr_stab_cnt u_stab (
        .clk      (clk),
        .rst      (rst),
        .load     (stab_load),
        .load_val (stab_ticks(ctrl.stab_sel)),
        .tick     (slow_tick),
        .busy     (stab_busy),
        .done     (stab_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_RUN;
            mode_q      <= MODE_IDLE;
            resume      <= 1'b0;
            tmr_invalid <= 1'b0;
        end else begin
            resume <= 1'b0;
            case (state)
                ST_RUN: begin
                    if (sleep_req && ctrl.sleep_en) begin
                        state       <= ST_SLEEP;
                        mode_q      <= ctrl.mode;
                        tmr_invalid <= 1'b0;
                    end
                end
                ST_SLEEP: begin
                    if (wake) begin
                        state <= ST_STAB;
                        if (mode_q == MODE_PSAVE && !tmr_async_sel) tmr_invalid <= 1'b1;
                    end
                end
                ST_STAB: begin
                    if (stab_done) begin
                        state  <= ST_RUN;
                        resume <= 1'b1;
                    end
                end
                default: state <= ST_RUN;
            endcase
        end
    end

    always_comb begin
        cpu_clk_en    = 1'b1;
        io_clk_en     = 1'b1;
        tmr_clk_en    = 1'b1;
        periph_clk_en = ~gate;
        if (state != ST_RUN) begin
            cpu_clk_en = 1'b0;
            if (mode_is_deep(mode_q)) begin
                io_clk_en     = 1'b0;
                periph_clk_en = '0;
                tmr_clk_en    = (mode_q == MODE_PSAVE) && tmr_async_sel;
            end
        end
    end

    assign asleep = (state != ST_RUN);

    // R2
    no_sleep_when_disabled_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && !ctrl.sleep_en) |=> (state == ST_RUN));

    // R6
    pdown_stays_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SLEEP && mode_q == MODE_PDOWN && !wk_ext_rst && !wk_wdt && !wk_bod
         && !wk_serial_start && !wk_pin_chg && wk_level == '0) |=> (state == ST_SLEEP));

    // R9
    resume_single_chk: assert property (@(posedge clk) disable iff (rst)
        resume |=> !resume);

    // R9
    cpu_return_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cpu_clk_en) |-> (resume && !stab_busy));

endmodule

// File: tb/sim_pwr_sleep_ctrl.sv
module sim_pwr_sleep_ctrl;

    localparam int NP = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic        sleep_req = 1'b0;
    logic        slow_tick = 1'b1;
    logic        wk_ext_rst = 1'b0, wk_wdt = 1'b0, wk_bod = 1'b0;
    logic        wk_serial_start = 1'b0, wk_pin_chg = 1'b0;
    logic [1:0]  wk_level = '0;
    logic        tmr_ovf_evt = 1'b0, tmr_cmp_evt = 1'b0;
    logic        tmr_ovf_ie = 1'b0, tmr_cmp_ie = 1'b0;
    logic        irq_global_en = 1'b0, tmr_async_sel = 1'b0;
    logic        cpu_clk_en, io_clk_en, tmr_clk_en, resume, asleep, tmr_invalid;
    logic [NP-1:0] periph_clk_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        int          req;
        logic [17:0] mask;
        logic [17:0] exp;
    } item_t;
    item_t sb_q[$];

    always #5 clk = ~clk;

    pwr_sleep_ctrl u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .sleep_req(sleep_req),
        .slow_tick(slow_tick), .wk_ext_rst(wk_ext_rst), .wk_wdt(wk_wdt),
        .wk_bod(wk_bod), .wk_serial_start(wk_serial_start), .wk_pin_chg(wk_pin_chg),
        .wk_level(wk_level), .tmr_ovf_evt(tmr_ovf_evt), .tmr_cmp_evt(tmr_cmp_evt),
        .tmr_ovf_ie(tmr_ovf_ie), .tmr_cmp_ie(tmr_cmp_ie), .irq_global_en(irq_global_en),
        .tmr_async_sel(tmr_async_sel), .cpu_clk_en(cpu_clk_en), .io_clk_en(io_clk_en),
        .tmr_clk_en(tmr_clk_en), .periph_clk_en(periph_clk_en), .resume(resume),
        .asleep(asleep), .tmr_invalid(tmr_invalid)
    );

    // Observation: [17:10] rdata, [9:6] periph, 5 tmr_invalid, 4 asleep,
    // 3 resume, 2 tmr clk, 1 io clk, 0 cpu clk
    logic [17:0] obs;
    assign obs = {cfg_rdata, periph_clk_en, tmr_invalid, asleep, resume,
                  tmr_clk_en, io_clk_en, cpu_clk_en};

    // Monitor: pops expectations and compares away from the active edge
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            checks++;
            if ((obs & it.mask) !== (it.exp & it.mask)) begin
                fails++;
                $display("FAIL R%0d: actual=%h expected=%h mask=%h", it.req,
                         obs & it.mask, it.exp & it.mask, it.mask);
            end
        end
    end

    task automatic push(int req, logic [17:0] mask, logic [17:0] exp);
        item_t it;
        it.req = req; it.mask = mask; it.exp = exp;
        sb_q.push_back(it);
    endtask

    task automatic exp_clk(int req, bit cpu, bit io, bit tm, bit slp, logic [NP-1:0] per);
        push(req, 18'h3D7, {8'h00, per, 1'b0, slp, 1'b0, tm, io, cpu});
    endtask

    task automatic exp_bit(int req, int idx, bit v);
        push(req, 18'(1) << idx, 18'(v) << idx);
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        step();
        cfg_we = 1'b0;
    endtask

    task automatic exp_rd(int req, logic [1:0] a, logic [7:0] v);
        cfg_addr = a;
        push(req, 18'h3FC00, {v, 10'h0});
        step();
    endtask

    task automatic go_sleep();
        sleep_req = 1'b1;
        step();
        sleep_req = 1'b0;
    endtask

    task automatic pulse_src(int k);
        case (k)
            0: wk_ext_rst = 1'b1;
            1: wk_wdt = 1'b1;
            2: wk_bod = 1'b1;
            3: wk_serial_start = 1'b1;
            default: wk_pin_chg = 1'b1;
        endcase
        step();
        wk_ext_rst = 1'b0; wk_wdt = 1'b0; wk_bod = 1'b0;
        wk_serial_start = 1'b0; wk_pin_chg = 1'b0;
    endtask

    // Called one delta after the edge that sampled the wake
    task automatic finish_wake(int n);
        exp_bit(9, 4, 1'b1);                       // R9 still asleep
        repeat (n) step();
        exp_bit(9, 4, 1'b1);                       // R9 counter just hit zero
        exp_bit(9, 3, 1'b0);
        step();
        exp_bit(9, 4, 1'b0);                       // R9 clocks back
        exp_bit(9, 0, 1'b1);
        exp_bit(9, 3, 1'b1);                       // R9 resume strobe
        step();
        exp_bit(9, 3, 1'b0);                       // R9 strobe lasts one cycle
        step();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1 reset state
        exp_clk(1, 1, 1, 1, 0, 4'hF);
        exp_bit(1, 3, 1'b0);
        exp_bit(1, 5, 1'b0);
        exp_rd(1, 2'd0, 8'h00);
        exp_rd(1, 2'd1, 8'h00);

        // R12 readback, R10 gating while running
        wr(2'd0, 8'h1D);
        exp_rd(12, 2'd0, 8'h1D);
        wr(2'd1, 8'h05);
        exp_rd(12, 2'd1, 8'h05);
        exp_clk(10, 1, 1, 1, 0, 4'hA);
        step();
        wr(2'd1, 8'h00);
        exp_clk(10, 1, 1, 1, 0, 4'hF);
        step();

        // R2 sleep request with enable clear
        wr(2'd0, 8'h04);
        go_sleep();
        exp_clk(2, 1, 1, 1, 0, 4'hF);
        step();

        // R4, R6: power-down, each source; timer events ignored
        wr(2'd0, 8'h05);
        tmr_async_sel = 1'b1; tmr_ovf_ie = 1'b1; tmr_cmp_ie = 1'b1; irq_global_en = 1'b1;
        for (int k = 0; k < 5; k++) begin
            go_sleep();
            exp_clk(4, 0, 0, 0, 1, 4'h0);          // R4
            tmr_ovf_evt = 1'b1; tmr_cmp_evt = 1'b1;
            step();
            tmr_ovf_evt = 1'b0; tmr_cmp_evt = 1'b0;
            step();
            exp_bit(6, 4, 1'b1);                   // R6 timer ignored in power-down
            step();
            pulse_src(k);                          // R6 source k
            finish_wake(6);
        end

        // R8 level hold, with delay select 1 (R9 16 ticks)
        wr(2'd0, 8'h0D);
        go_sleep();
        wk_level[0] = 1'b1;
        repeat (3) step();
        wk_level[0] = 1'b0;
        step();
        exp_bit(8, 4, 1'b1);                       // R8 short pulse ignored
        step();
        wk_level[1] = 1'b1;
        repeat (4) step();
        wk_level[1] = 1'b0;
        finish_wake(16);                           // R8 held pulse wakes

        // R5, R7: power-save with async timer
        wr(2'd0, 8'h07);
        tmr_async_sel = 1'b1; irq_global_en = 1'b0; tmr_ovf_ie = 1'b1; tmr_cmp_ie = 1'b0;
        go_sleep();
        exp_clk(5, 0, 0, 1, 1, 4'h0);              // R5
        tmr_ovf_evt = 1'b1; step(); tmr_ovf_evt = 1'b0;
        exp_bit(7, 4, 1'b1);                       // R7 global enable off
        step();
        irq_global_en = 1'b1; tmr_ovf_ie = 1'b0;
        tmr_ovf_evt = 1'b1; step(); tmr_ovf_evt = 1'b0;
        exp_bit(7, 4, 1'b1);                       // R7 own enable off
        step();
        tmr_cmp_ie = 1'b1;
        tmr_cmp_evt = 1'b1; step(); tmr_cmp_evt = 1'b0;
        finish_wake(6);                            // R7 enabled compare wakes
        exp_bit(11, 5, 1'b0);                      // R11 not set with async clock
        step();

        // R11: power-save without async clock
        tmr_async_sel = 1'b0;
        go_sleep();
        exp_clk(5, 0, 0, 0, 1, 4'h0);              // R5 timer gated
        tmr_cmp_evt = 1'b1; step(); tmr_cmp_evt = 1'b0;
        exp_bit(7, 4, 1'b1);                       // R7 needs async select
        step();
        pulse_src(2);
        finish_wake(6);
        exp_bit(11, 5, 1'b1);                      // R11 flagged
        step();
        wr(2'd0, 8'h05);
        go_sleep();
        exp_bit(11, 5, 1'b0);                      // R11 cleared on entry
        step();
        pulse_src(4);
        finish_wake(6);

        // R3 idle and reserved, R7 timer wake in idle
        wr(2'd1, 8'h03);
        wr(2'd0, 8'h01);
        tmr_async_sel = 1'b1;
        go_sleep();
        exp_clk(3, 0, 1, 1, 1, 4'hC);              // R3 idle code 00
        step();
        tmr_cmp_evt = 1'b1; step(); tmr_cmp_evt = 1'b0;
        finish_wake(6);                            // R7 idle timer wake
        wr(2'd0, 8'h03);
        go_sleep();
        exp_clk(3, 0, 1, 1, 1, 4'hC);              // R3 reserved code 01
        step();
        pulse_src(1);
        finish_wake(6);
        wr(2'd1, 8'h00);

        // R9 counter frozen without slow tick
        wr(2'd0, 8'h05);
        go_sleep();
        slow_tick = 1'b0;
        pulse_src(0);
        repeat (20) step();
        exp_bit(9, 4, 1'b1);                       // R9 no progress without tick
        step();
        slow_tick = 1'b1;
        finish_wake(6);

        step();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule